// File: doc/BRIEF.md
# Clock-Reset Status and Interrupt Flags

This block is the status and interrupt corner of a clock and reset generator. It records clock events and reset causes as sticky flags that software clears by writing one to the bit. It also shows the present PLL-lock and self-clock-mode levels, and it drives one interrupt request. The events it records are a real-time-interrupt timeout pulse, a change of the lock level, a change of the self-clock-mode level, and three reset causes: power-on, low-voltage and illegal-address.

Software reaches the block through a byte-wide register port. The port has an address, a write strobe, write data and combinational read data. A flag register holds the flags and the live levels. An enable register holds one enable bit for each interruptible flag. Each interruptible flag is masked by its enable, the masked flags are ORed, and the result is registered onto the interrupt output. The reset-cause flags have no enable bit and never reach the interrupt output. They are kept through the synchronous block reset, so software can still read why the chip was reset. The power-on cause input sets them to a known state.

Top module: `crg_status_regs`

## Requirements
- R1: The flag register is at offset 0x03. Its bit positions are: bit 7 timeout flag, bit 6 power-on flag, bit 5 low-voltage flag, bit 4 lock-change flag, bit 3 live lock, bit 2 illegal-address flag, bit 1 self-clock-change flag, bit 0 live self-clock mode. A read at any offset other than 0x03 or 0x04 returns 0x00.
- R2: The enable register is at offset 0x04. Bit 7 enables the timeout interrupt, bit 4 the lock-change interrupt and bit 1 the self-clock-change interrupt. All other bits read 0 and ignore writes.
- R3: Writing 1 to bit 7, 6, 5, 4, 2 or 1 of offset 0x03 clears that flag after the write edge. Writing 0 leaves the flag unchanged.
- R4: A one-cycle `rti_tick` pulse sets the timeout flag at the next clock edge.
- R5: The lock-change flag sets at the edge after the effective lock level changes, both on a fall and on a rise.
- R6: The self-clock-change flag sets at the edge after `scm_active` changes, both on a rise and on a fall.
- R7: Live lock reads 0 while `scm_active` is 1, whatever `pll_lock` is. A change of `pll_lock` while `scm_active` is 1 sets no flag. Writes to bits 3 and 0 of offset 0x03 have no effect.
- R8: `por_cause` sets the power-on flag, `lvr_cause` sets the low-voltage flag and `ila_cause` sets the illegal-address flag. These three flags keep their value through `rst_n` and never assert `irq`.
- R9: When a hardware set and a write-one-clear hit the same flag in the same cycle, the flag ends up set.
- R10: `irq` is registered. In each cycle it equals the OR of the three enabled flag/enable pairs as they stood one cycle earlier. A flag whose enable bit is 0 never asserts `irq`.
- R11: While `rst_n` is low, the enable register, `irq` and the three event flags are cleared. Releasing reset with a stable lock or mode level sets no change flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | ADDR_W | Register offset for reads and writes |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| rti_tick | input | 1 | Pulse at the end of each real-time period |
| por_cause | input | 1 | Power-on reset cause, also sets the cause flags to a known state |
| lvr_cause | input | 1 | Low-voltage reset cause |
| ila_cause | input | 1 | Illegal-address reset cause |
| pll_lock | input | 1 | PLL lock level |
| scm_active | input | 1 | Self-clock-mode level |
| irq | output | 1 | Combined registered interrupt request |

## Verification
The checker watches several behaviours on every cycle: the registered masking of `irq`, the setting of flags by a tick or by a change of either level, the forcing of lock to 0 in self-clock mode, the reserved enable bits reading 0, and the holding of the power-on flag unless it is written. Some behaviours only the directed scenarios can show. These are the full bit layout of the flag register, clear-by-one against write-zero, a set that wins over a clear in the same cycle, a lock change that is hidden during self-clock mode, and cause flags that survive a block reset while the enables and event flags return to zero.

// File: rtl/crg_status_pkg.sv
// Package crg_status_pkg
// Shared bit positions and widths for the clock-reset status block.
// Assumes byte-wide registers; the bit positions are what software decodes.
package crg_status_pkg;

    localparam int REG_W   = 8;
    localparam int N_EVT   = 3;   // interruptible event flags
    localparam int N_CAUSE = 3;   // reset-cause flags
    localparam int N_LVL   = 2;   // watched status levels

    // Flag register bit positions (decoded by software)
    localparam int B_TMO     = 7;
    localparam int B_POR     = 6;
    localparam int B_LVR     = 5;
    localparam int B_LOCKCHG = 4;
    localparam int B_LOCK    = 3;
    localparam int B_ILA     = 2;
    localparam int B_MODECHG = 1;
    localparam int B_MODE    = 0;

    // Event-flag vector index: which flag sits in which slot
    localparam int E_TMO  = 2;
    localparam int E_LOCK = 1;
    localparam int E_MODE = 0;

    // Cause-flag vector index
    localparam int C_POR = 2;
    localparam int C_LVR = 1;
    localparam int C_ILA = 0;

    // Level-watch vector index
    localparam int L_LOCK = 1;
    localparam int L_MODE = 0;

    // Enable bits share the positions of the flags they mask
    localparam logic [REG_W-1:0] EN_MASK =
        (REG_W'(1) << B_TMO) | (REG_W'(1) << B_LOCKCHG) | (REG_W'(1) << B_MODECHG);

endpackage

// File: rtl/crg_level_watch.sv
// Module crg_level_watch
// Compares each status level with a copy registered one cycle earlier and
// reports a change for one cycle. The copy follows the input in reset too,
// so releasing reset never reports a change that did not happen.
// Assumes the levels are already synchronous to clk.
module crg_level_watch #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] level_i,
    output logic [N-1:0] changed_o
);

    logic [N-1:0] prev_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        // Track the previous level, in and out of reset alike
        always_ff @(posedge clk) begin
            prev_q[i] <= level_i[i];
        end

        // Flag a change only outside reset
        assign changed_o[i] = rst_n & (level_i[i] ^ prev_q[i]);
    end

endmodule

// File: rtl/crg_sticky_bits.sv
// Module crg_sticky_bits
// A bank of sticky flags: a hardware set wins over a write-one-clear.
// RETAIN = 0: the flags are cleared by rst_n.
// RETAIN = 1: the flags are kept through rst_n and loaded from init_val_i
// while init_i is high; sets are still recorded during rst_n.
module crg_sticky_bits #(
    parameter int N      = 3,
    parameter bit RETAIN = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    input  logic         init_i,
    input  logic [N-1:0] init_val_i,
    output logic [N-1:0] flag_o
);

    logic [N-1:0] flag_q;

    if (RETAIN) begin : g_retain
        // Keep flags through block reset; init_i sets the known state
        always_ff @(posedge clk) begin
            if (init_i)
                flag_q <= init_val_i;
            else if (rst_n)
                flag_q <= (flag_q & ~clr_i) | set_i;
            else
                flag_q <= flag_q | set_i;
        end
    end else begin : g_clear
        logic unused_init;
        assign unused_init = ^{init_i, init_val_i};

        // Cleared by reset; set dominates clear
        always_ff @(posedge clk) begin
            if (!rst_n)
                flag_q <= '0;
            else
                flag_q <= (flag_q & ~clr_i) | set_i;
        end
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/crg_irq_unit.sv
// Module crg_irq_unit
// Holds the interrupt enable bits and drives the combined request register.
// The request reflects flags and enables as they stood before the edge.
module crg_irq_unit #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_we_i,
    input  logic [N-1:0] en_wdata_i,
    input  logic [N-1:0] flags_i,
    output logic [N-1:0] en_o,
    output logic         irq_o
);

    logic [N-1:0] en_q;
    logic         irq_q;

    // Enable register, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= '0;
        else if (en_we_i)
            en_q <= en_wdata_i;
    end

    // Registered OR of masked flags
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else
            irq_q <= |(flags_i & en_q);
    end

    assign en_o  = en_q;
    assign irq_o = irq_q;

endmodule

// File: rtl/crg_status_regs.sv
// Module crg_status_regs (top)
// Status flags, reset causes and the interrupt request of a clock-reset
// generator, behind a byte register port with combinational reads.
// Assumes all inputs are synchronous to clk and rst_n is synchronous.
module crg_status_regs
    import crg_status_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] FLAG_OFS  = ADDR_W'(3),
    parameter logic [ADDR_W-1:0] INTEN_OFS = ADDR_W'(4)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              rti_tick,
    input  logic              por_cause,
    input  logic              lvr_cause,
    input  logic              ila_cause,
    input  logic              pll_lock,
    input  logic              scm_active,
    output logic              irq
);

    logic               hit_flag, hit_en;
    logic               lock_eff;
    logic [N_LVL-1:0]   levels, changed;
    logic [N_EVT-1:0]   evt_set, evt_clr, evt_q;
    logic [N_CAUSE-1:0] cause_set, cause_clr, cause_init, cause_q;
    logic [N_EVT-1:0]   en_wdata, en_q;
    logic [REG_W-1:0]   flag_vec, en_vec;
    logic               unused_wbits;

    // Address decode for writes
    assign hit_flag = reg_wr && (reg_addr == FLAG_OFS);
    assign hit_en   = reg_wr && (reg_addr == INTEN_OFS);

    // Lock reads low whenever the part runs on its self clock
    assign lock_eff       = pll_lock & ~scm_active;
    assign levels[L_LOCK] = lock_eff;
    assign levels[L_MODE] = scm_active;

    crg_level_watch #(.N(N_LVL)) u_watch (
        .clk       (clk),
        .rst_n     (rst_n),
        .level_i   (levels),
        .changed_o (changed)
    );

    // Event flags: set sources and write-one-clear
    assign evt_set[E_TMO]  = rti_tick;
    assign evt_set[E_LOCK] = changed[L_LOCK];
    assign evt_set[E_MODE] = changed[L_MODE];
    assign evt_clr[E_TMO]  = hit_flag & reg_wdata[B_TMO];
    assign evt_clr[E_LOCK] = hit_flag & reg_wdata[B_LOCKCHG];
    assign evt_clr[E_MODE] = hit_flag & reg_wdata[B_MODECHG];

    crg_sticky_bits #(.N(N_EVT), .RETAIN(1'b0)) u_evt (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (evt_set),
        .clr_i      (evt_clr),
        .init_i     (1'b0),
        .init_val_i ('0),
        .flag_o     (evt_q)
    );

    // Reset-cause flags: kept through rst_n, initialised by power-on
    assign cause_set[C_POR]  = por_cause;
    assign cause_set[C_LVR]  = lvr_cause;
    assign cause_set[C_ILA]  = ila_cause;
    assign cause_clr[C_POR]  = rst_n & hit_flag & reg_wdata[B_POR];
    assign cause_clr[C_LVR]  = rst_n & hit_flag & reg_wdata[B_LVR];
    assign cause_clr[C_ILA]  = rst_n & hit_flag & reg_wdata[B_ILA];
    assign cause_init[C_POR] = 1'b1;
    assign cause_init[C_LVR] = lvr_cause;
    assign cause_init[C_ILA] = ila_cause;

    crg_sticky_bits #(.N(N_CAUSE), .RETAIN(1'b1)) u_cause (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (cause_set),
        .clr_i      (cause_clr),
        .init_i     (por_cause),
        .init_val_i (cause_init),
        .flag_o     (cause_q)
    );

    // Enable write data picked from the positions of the flags
    assign en_wdata[E_TMO]  = reg_wdata[B_TMO];
    assign en_wdata[E_LOCK] = reg_wdata[B_LOCKCHG];
    assign en_wdata[E_MODE] = reg_wdata[B_MODECHG];

    crg_irq_unit #(.N(N_EVT)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_we_i    (hit_en),
        .en_wdata_i (en_wdata),
        .flags_i    (evt_q),
        .en_o       (en_q),
        .irq_o      (irq)
    );

    // Assemble the flag register image
    always_comb begin
        flag_vec            = '0;
        flag_vec[B_TMO]     = evt_q[E_TMO];
        flag_vec[B_POR]     = cause_q[C_POR];
        flag_vec[B_LVR]     = cause_q[C_LVR];
        flag_vec[B_LOCKCHG] = evt_q[E_LOCK];
        flag_vec[B_LOCK]    = lock_eff;
        flag_vec[B_ILA]     = cause_q[C_ILA];
        flag_vec[B_MODECHG] = evt_q[E_MODE];
        flag_vec[B_MODE]    = scm_active;
    end

    // Assemble the enable register image, reserved bits zero
    always_comb begin
        en_vec              = '0;
        en_vec[B_TMO]       = en_q[E_TMO];
        en_vec[B_LOCKCHG]   = en_q[E_LOCK];
        en_vec[B_MODECHG]   = en_q[E_MODE];
    end

    // Read multiplexer; unmapped offsets read zero
    always_comb begin
        if (reg_addr == FLAG_OFS)
            reg_rdata = flag_vec;
        else if (reg_addr == INTEN_OFS)
            reg_rdata = en_vec;
        else
            reg_rdata = '0;
    end

    assign unused_wbits = ^{reg_wdata[B_LOCK], reg_wdata[B_MODE]};

endmodule

// File: rtl/crg_status_regs_chk.sv
// Module crg_status_regs_chk
// Cycle-by-cycle properties of crg_status_regs, attached by bind below.
module crg_status_regs_chk #(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] FLAG_OFS  = ADDR_W'(3),
    parameter logic [ADDR_W-1:0] INTEN_OFS = ADDR_W'(4)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic [7:0]        reg_wdata,
    input logic [7:0]        reg_rdata,
    input logic              rti_tick,
    input logic              pll_lock,
    input logic              scm_active,
    input logic              irq,
    input logic [7:0]        flags,
    input logic [2:0]        en
);

    // R10: request follows the masked flags one cycle later
    a_r10_irq_registered: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> irq == $past((flags[7] & en[2]) | (flags[4] & en[1]) | (flags[1] & en[0])));

    // R4: a tick sets the timeout flag at the next edge
    a_r4_tick_sets: assert property (@(posedge clk) disable iff (!rst_n)
        rti_tick |=> flags[7]);

    // R5: any change of effective lock sets the lock-change flag
    a_r5_lock_change: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pll_lock & ~scm_active) |=> flags[4]);

    // R6: any change of the mode level sets the mode-change flag
    a_r6_mode_change: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(scm_active) |=> flags[1]);

    // R7: lock reads zero during self-clock mode
    a_r7_lock_forced: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == FLAG_OFS && scm_active) |-> !reg_rdata[3]);

    // R2: reserved enable bits read zero
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == INTEN_OFS) |-> ((reg_rdata & 8'h6D) == 8'h00));

    // R8: power-on flag holds unless written with one
    a_r8_cause_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[6] && !(reg_wr && reg_addr == FLAG_OFS && reg_wdata[6])) |=> flags[6]);

endmodule

bind crg_status_regs crg_status_regs_chk #(
    .ADDR_W    (ADDR_W),
    .FLAG_OFS  (FLAG_OFS),
    .INTEN_OFS (INTEN_OFS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_addr   (reg_addr),
    .reg_wr     (reg_wr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .rti_tick   (rti_tick),
    .pll_lock   (pll_lock),
    .scm_active (scm_active),
    .irq        (irq),
    .flags      (flag_vec),
    .en         (en_q)
);

// File: tb/crg_status_regs_test.sv
// Directed bench for crg_status_regs: one task per scenario.
module crg_status_regs_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] reg_addr;
    logic       reg_wr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic       rti_tick, por_cause, lvr_cause, ila_cause;
    logic       pll_lock, scm_active;
    logic       irq;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;   // 50 MHz

    crg_status_regs uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_addr   (reg_addr),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .rti_tick   (rti_tick),
        .por_cause  (por_cause),
        .lvr_cause  (lvr_cause),
        .ila_cause  (ila_cause),
        .pll_lock   (pll_lock),
        .scm_active (scm_active),
        .irq        (irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] a, input string req, input logic [7:0] exp);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        step();
        reg_wr    = 1'b0;
    endtask

    task automatic tick();
        rti_tick = 1'b1;
        step();
        rti_tick = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; por_cause = 1'b1; lvr_cause = 1'b0; ila_cause = 1'b0;
        rti_tick = 1'b0; pll_lock = 1'b1; scm_active = 1'b0;
        reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        @(negedge clk);
        step(); step();
        por_cause = 1'b0;
        step();
        rst_n = 1'b1;
        step();
        rd(8'h03, "R11 no spurious flag, R8 power-on flag", 8'h48);
        rd(8'h04, "R11 enables cleared", 8'h00);
        check("R11 irq low", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_offsets();
        rd(8'h00, "R1 unmapped 0x00", 8'h00);
        rd(8'h02, "R1 unmapped 0x02", 8'h00);
        rd(8'h05, "R1 unmapped 0x05", 8'h00);
        rd(8'h80, "R1 unmapped 0x80", 8'h00);
    endtask

    task automatic t_w1c();
        wr(8'h03, 8'h00);
        rd(8'h03, "R3 write zero keeps", 8'h48);
        wr(8'h03, 8'h09);
        rd(8'h03, "R7 status bits not writable", 8'h48);
        wr(8'h03, 8'h40);
        rd(8'h03, "R3 write one clears", 8'h08);
    endtask

    task automatic t_enable();
        wr(8'h04, 8'hFF);
        rd(8'h04, "R2 enable bits", 8'h92);
        wr(8'h04, 8'h6D);
        rd(8'h04, "R2 reserved ignored", 8'h00);
    endtask

    task automatic t_tick_irq();
        wr(8'h04, 8'h80);
        tick();
        rd(8'h03, "R4 timeout flag", 8'h88);
        check("R10 irq one cycle later", {7'd0, irq}, 8'h00);
        step();
        check("R10 irq asserted", {7'd0, irq}, 8'h01);
        wr(8'h03, 8'h80);
        rd(8'h03, "R3 timeout cleared", 8'h08);
        check("R10 irq lags clear", {7'd0, irq}, 8'h01);
        step();
        check("R10 irq dropped", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_mask();
        wr(8'h04, 8'h00);
        tick();
        step(); step();
        check("R10 masked flag no irq", {7'd0, irq}, 8'h00);
        rd(8'h03, "R4 flag set while masked", 8'h88);
        wr(8'h03, 8'h80);
    endtask

    task automatic t_lock();
        wr(8'h04, 8'h10);
        pll_lock = 1'b0;
        step();
        rd(8'h03, "R5 lock fall", 8'h10);
        step();
        check("R10 lock irq", {7'd0, irq}, 8'h01);
        wr(8'h03, 8'h10);
        step();
        check("R10 lock irq dropped", {7'd0, irq}, 8'h00);
        pll_lock = 1'b1;
        step();
        rd(8'h03, "R5 lock rise", 8'h18);
        wr(8'h03, 8'h10);
        rd(8'h03, "R3 lock flag cleared", 8'h08);
    endtask

    task automatic t_mode();
        wr(8'h04, 8'h02);
        scm_active = 1'b1;
        step();
        rd(8'h03, "R6 mode rise, R7 lock forced low", 8'h13);
        step();
        check("R10 mode irq", {7'd0, irq}, 8'h01);
        wr(8'h03, 8'h12);
        rd(8'h03, "R3 change flags cleared", 8'h01);
        pll_lock = 1'b0;
        step();
        pll_lock = 1'b1;
        step();
        rd(8'h03, "R7 lock hidden in self-clock", 8'h01);
        scm_active = 1'b0;
        step();
        rd(8'h03, "R6 mode fall", 8'h1A);
        wr(8'h03, 8'h12);
        rd(8'h03, "R3 after mode fall", 8'h08);
        step();
    endtask

    task automatic t_set_wins();
        wr(8'h04, 8'h00);
        tick();
        reg_addr = 8'h03; reg_wdata = 8'h80; reg_wr = 1'b1; rti_tick = 1'b1;
        step();
        reg_wr = 1'b0; rti_tick = 1'b0;
        rd(8'h03, "R9 set wins over clear", 8'h88);
        wr(8'h03, 8'h80);
        rd(8'h03, "R9 later clear works", 8'h08);
    endtask

    task automatic t_causes();
        wr(8'h04, 8'hFF);
        lvr_cause = 1'b1; ila_cause = 1'b1;
        step();
        lvr_cause = 1'b0; ila_cause = 1'b0;
        rd(8'h03, "R8 cause flags", 8'h2C);
        step(); step();
        check("R8 causes raise no irq", {7'd0, irq}, 8'h00);
        rst_n = 1'b0;
        step(); step();
        rst_n = 1'b1;
        step();
        rd(8'h03, "R8 causes survive reset", 8'h2C);
        rd(8'h04, "R11 enables reset", 8'h00);
        wr(8'h03, 8'h24);
        rd(8'h03, "R3 cause flags cleared", 8'h08);
    endtask

    initial begin
        t_reset();
        t_offsets();
        t_w1c();
        t_enable();
        t_tick_irq();
        t_mask();
        t_lock();
        t_mode();
        t_set_wins();
        t_causes();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule